// File: doc/BRIEF.md
# Transition-Driven Set/Clear Flag

This block keeps a single status flag that is steered by two event lines using transition signalling, as a two-phase handshake does. Every change of level on the clear line, whether rising or falling, drives the flag low. Every change of level on the set line drives it high. Only the change matters; the absolute level of a line carries no meaning.

Both event lines may come from another clock domain. Each passes through its own synchroniser chain. A change is then found by comparing the synchronised level with a registered copy of the previous sample. Each line also has a one-cycle strobe output that marks each detected change. The two lines are expected never to change together. If both changes land in the same cycle, the set side takes priority and a sticky collision bit is raised, which only reset clears.

The flag is a two-state machine with the states FLAG_LOW and FLAG_HIGH. It has four named transitions: RAISE (FLAG_LOW to FLAG_HIGH on a set change), DROP (FLAG_HIGH to FLAG_LOW on a clear change with no set change), HOLD (no change seen, so the state is kept) and CLASH (both changes seen, so the state goes to or stays at FLAG_HIGH).

Top module: `tflag_top`

## Requirements
- R1: While rst_n is low and directly after reset, flag_o, clr_strobe_o, set_strobe_o and collide_o are all 0.
- R2: A change of clr_evt_i in either direction, with no set change detected in the same cycle, makes flag_o 0.
- R3: A change of set_evt_i in either direction makes flag_o 1.
- R4: Each change of an event input gives exactly one cycle of the matching strobe output at 1.
- R5: The strobe output rises SYNC_STAGES clock edges after the input change is sampled. flag_o takes its new value one edge after that, which is three edges with the default of two stages.
- R6: While neither input changes, flag_o keeps its value and both strobes stay 0.
- R7: Changes of both inputs detected in the same cycle make flag_o 1 and set collide_o. collide_o then stays 1 until reset.
- R8: The previous-level registers reset to 0. An input that is held at 1 through reset is therefore reported after release as one change, with a strobe and its effect on flag_o.
- R9: A change that drives the flag to the value it already holds leaves flag_o unchanged, but the strobe still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_evt_i | input | 1 | Clear event line; any change of level clears the flag |
| set_evt_i | input | 1 | Set event line; any change of level sets the flag |
| flag_o | output | 1 | Status flag |
| clr_strobe_o | output | 1 | One-cycle pulse for each detected clear change |
| set_strobe_o | output | 1 | One-cycle pulse for each detected set change |
| collide_o | output | 1 | Sticky: both changes seen in one cycle |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that value the strobe is sampled two edges after an input change and the flag three edges after it, at fixed cycle positions. Same-cycle changes can be forced by toggling both inputs at one falling clock edge, which brings the CLASH transition and the sticky collision bit within reach. Holding an input high through reset brings the previous-level reset value within reach.

// File: rtl/tflag_pkg.sv
package tflag_pkg;

    typedef enum logic [0:0] {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic clr;
        logic set;
    } evt_pair_t;

endpackage

// File: rtl/tflag_sync.sv
module tflag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/tflag_edge.sv
module tflag_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic strobe_o
);

    logic prev_q;

    // Previous-level register resets to 0 (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign strobe_o = level_i ^ prev_q;

    // R4
    strobe_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !$stable(prev_q));

    // R6
    quiet_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |=> $stable(prev_q));

endmodule

// File: rtl/tflag_fsm.sv
module tflag_fsm
    import tflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  evt_pair_t hit_i,
    output logic      flag_o,
    output logic      collide_o
);

    flag_state_e state_q, state_d;
    logic        collide_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= FLAG_LOW;
            collide_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            collide_q <= collide_q | (hit_i.clr & hit_i.set);
        end
    end

    // Next-state: RAISE, DROP, HOLD, CLASH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW: begin
                if (hit_i.set) state_d = FLAG_HIGH;
            end
            FLAG_HIGH: begin
                if (hit_i.clr && !hit_i.set) state_d = FLAG_LOW;
            end
            default: state_d = FLAG_LOW;
        endcase
    end

    // Outputs
    always_comb begin
        flag_o    = (state_q == FLAG_HIGH);
        collide_o = collide_q;
    end

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> (!flag_o && !collide_o));

    // R2
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i.clr && !hit_i.set) |=> !flag_o);

    // R3
    set_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i.set |=> flag_o);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i.clr && !hit_i.set) |=> $stable(flag_o));

    // R7
    clash_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i.clr && hit_i.set) |=> collide_o);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide_o |=> collide_o);

endmodule

// File: rtl/tflag_top.sv
module tflag_top
    import tflag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_evt_i,
    input  logic set_evt_i,
    output logic flag_o,
    output logic clr_strobe_o,
    output logic set_strobe_o,
    output logic collide_o
);

    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lvl;
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] strobe;
    evt_pair_t            hits;

    assign raw_lvl = {set_evt_i, clr_evt_i};

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            tflag_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (raw_lvl[i]),
                .sync_o  (sync_lvl[i])
            );
            tflag_edge u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .level_i  (sync_lvl[i]),
                .strobe_o (strobe[i])
            );
        end
    endgenerate

    assign hits.clr = strobe[0];
    assign hits.set = strobe[1];

    tflag_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hits),
        .flag_o    (flag_o),
        .collide_o (collide_o)
    );

    assign clr_strobe_o = strobe[0];
    assign set_strobe_o = strobe[1];

    // R1
    reset_strobe_chk: assert property (@(posedge clk)
        !rst_n |-> (!clr_strobe_o && !set_strobe_o));

endmodule

// File: tb/tflag_top_tb.sv
module tflag_top_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_evt = 1'b0;
    logic set_evt = 1'b0;
    logic flag, clr_stb, set_stb, collide;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tflag_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_evt_i    (clr_evt),
        .set_evt_i    (set_evt),
        .flag_o       (flag),
        .clr_strobe_o (clr_stb),
        .set_strobe_o (set_stb),
        .collide_o    (collide)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Toggle one line at a falling edge, then check strobe and flag timing.
    task automatic toggle_line(input bit is_set, input logic flag_before,
                               input logic flag_after, input string req);
        @(negedge clk);
        if (is_set) set_evt = ~set_evt; else clr_evt = ~clr_evt;
        @(negedge clk);
        chk(req, "strobe early", is_set ? set_stb : clr_stb, 1'b0);
        @(negedge clk);
        chk("R5", "strobe at 2 edges", is_set ? set_stb : clr_stb, 1'b1);
        chk("R5", "flag still old", flag, flag_before);
        @(negedge clk);
        chk(req, "flag after 3 edges", flag, flag_after);
        chk("R4", "strobe one cycle", is_set ? set_stb : clr_stb, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "flag in reset", flag, 1'b0);
        chk("R1", "clr strobe in reset", clr_stb, 1'b0);
        chk("R1", "set strobe in reset", set_stb, 1'b0);
        chk("R1", "collide in reset", collide, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "flag after reset", flag, 1'b0);
    endtask

    task automatic t_both_polarities();
        toggle_line(1'b1, 1'b0, 1'b1, "R3");  // set rises
        toggle_line(1'b0, 1'b1, 1'b0, "R2");  // clr rises
        toggle_line(1'b1, 1'b0, 1'b1, "R3");  // set falls
        toggle_line(1'b0, 1'b1, 1'b0, "R2");  // clr falls
    endtask

    task automatic t_redundant();
        toggle_line(1'b0, 1'b0, 1'b0, "R9");  // clear while low
        toggle_line(1'b1, 1'b0, 1'b1, "R3");
        toggle_line(1'b1, 1'b1, 1'b1, "R9");  // set while high
    endtask

    task automatic t_hold();
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            seen = seen | clr_stb | set_stb;
            chk("R6", "flag held", flag, 1'b1);
        end
        chk("R6", "no strobe while quiet", seen, 1'b0);
    endtask

    task automatic t_clash();
        toggle_line(1'b0, 1'b1, 1'b0, "R2");
        chk("R7", "no collide yet", collide, 1'b0);
        @(negedge clk);
        clr_evt = ~clr_evt;
        set_evt = ~set_evt;
        repeat (2) @(negedge clk);
        chk("R7", "both strobes", clr_stb & set_stb, 1'b1);
        @(negedge clk);
        chk("R7", "set wins", flag, 1'b1);
        chk("R7", "collide raised", collide, 1'b1);
        toggle_line(1'b0, 1'b1, 1'b0, "R2");
        chk("R7", "collide sticky", collide, 1'b1);
        do_reset();
        @(negedge clk);
        chk("R7", "collide cleared by reset", collide, 1'b0);
    endtask

    task automatic t_high_through_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clr_evt = 1'b0;
        set_evt = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "flag low in reset", flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "no strobe yet", set_stb, 1'b0);
        @(negedge clk);
        chk("R8", "strobe for held high", set_stb, 1'b1);
        @(negedge clk);
        chk("R8", "flag set by held high", flag, 1'b1);
        chk("R8", "strobe once", set_stb, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8", "no second strobe", set_stb, 1'b0);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin : main
        t_reset();
        t_both_polarities();
        t_redundant();
        t_hold();
        t_clash();
        t_high_through_reset();
        report();
        $finish;
    end

endmodule